// File: doc/BRIEF.md
# Global-Stall Valid/Ready Pipeline Controller

This block governs a fixed-depth chain of data registers that carry no reset of their own. It keeps one valid flag per register stage and drives a single enable, `pipe_en`, that goes to the clock-enable of every data register. The whole chain therefore advances or stalls as one unit. On the upstream side it offers a valid/ready handshake to the producer, and on the downstream side it presents a valid/ready handshake to the consumer. A clock-enable input, `ce`, freezes the stages and both handshakes.

Each cycle, a small combinational flow classifier puts the controller into one of three named states. `FLOW_RUN` is the case where the last stage is empty or the consumer is ready, and the pipeline moves. `FLOW_BLOCKED` is the case where the last stage holds an item and the consumer is not ready, and everything holds. `FLOW_FROZEN` is the case where `ce` is low, and everything holds. There is no registered state: the state follows the current inputs. Move into `FLOW_FROZEN` whenever `ce` falls. Move into `FLOW_BLOCKED` when `ce` is high, the last flag is set and `out_ready` is low. Otherwise the state is `FLOW_RUN`.

Empty slots (bubbles) travel down the chain like items and are never collapsed. The stage count includes the input and output registers. For example, an input register, then some logic, then an output register is a count of 2. A data register chain of parameterised width is included as the companion datapath.

Top module: `stall_pipe_ctrl`

## Requirements
- R1: While the reset input is at its active level (parameter `RST_ACTIVE`, default 1), all valid flags clear on the next rising edge, so `out_valid` is low, whatever the data registers hold.
- R2: `in_ready` is high whenever `ce` is high and either the last stage is empty or `out_ready` is high.
- R3: `pipe_en` always equals `in_ready`, and both are low whenever `ce` is low.
- R4: While `ce` is low, no input is accepted, and the valid flags and `out_data` keep their values.
- R5: When the last stage is valid and `out_ready` is low, `pipe_en` and `in_ready` are low, and `out_valid` and `out_data` hold.
- R6: `out_valid` is the valid flag of the last stage, and `out_data` is driven directly from the last data register.
- R7: On each edge with `pipe_en` high, the first flag takes `in_valid` and each later flag takes its predecessor. A bubble at the input therefore appears at `out_valid` exactly `STAGES` cycles later.
- R8: The data chain moves a word forward one register per edge, and only on edges where `pipe_en` is high.
- R9: With `ce` and `out_ready` held high, one item is accepted every cycle, and each item appears at the output exactly `STAGES` cycles after the cycle in which it was accepted.
- R10: Items leave in acceptance order, with none lost or duplicated, under random `in_valid` and `out_ready`. An upstream transfer is a cycle with `in_valid` and `in_ready` both high. A downstream transfer is a cycle with `out_valid`, `out_ready` and `pipe_en` all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active at `RST_ACTIVE` |
| ce | input | 1 | Active-high clock enable; low freezes the pipeline |
| in_valid | input | 1 | Producer has a word on `in_data` |
| in_ready | output | 1 | Pipeline accepts a word this cycle |
| in_data | input | WIDTH | Word entering the first stage |
| out_valid | output | 1 | Last stage holds a valid word |
| out_ready | input | 1 | Consumer can take the word |
| out_data | output | WIDTH | Word in the last stage |
| pipe_en | output | 1 | Shared enable for every data register |

## Verification
The assertions check the following on every cycle: that the flags hold whenever the enable is low, that the first flag follows `in_valid` after an enabled edge, that a blocked last stage forces the enable low, and that `out_data` never moves while the enable is low. Other behaviours can only be shown by the directed scenarios. These are the exact `STAGES`-cycle latency, the full one-per-cycle throughput, the preservation of bubble patterns, the pipeline holding exactly `STAGES` items under backpressure, and the in-order, lossless delivery under random handshakes checked against a scoreboard. The scenarios also cover a reset in mid-stream, and the `ce` freeze with the consumer ready.

// File: rtl/stall_pipe_pkg.sv
`timescale 1ns/1ps
package stall_pipe_pkg;

    // Combinational flow classification of the controller
    typedef enum logic [1:0] {
        FLOW_RUN     = 2'd0,
        FLOW_BLOCKED = 2'd1,
        FLOW_FROZEN  = 2'd2
    } flow_e;

endpackage

// File: rtl/stall_flow_ctl.sv
`timescale 1ns/1ps
module stall_flow_ctl
    import stall_pipe_pkg::*;
(
    input  logic  ce,
    input  logic  last_valid,
    input  logic  sink_ready,
    output flow_e flow,
    output logic  advance
);

    // Classify the current cycle
    always_comb begin
        if (!ce) begin
            flow = FLOW_FROZEN;
        end else if (last_valid && !sink_ready) begin
            flow = FLOW_BLOCKED;
        end else begin
            flow = FLOW_RUN;
        end
    end

    // Enable output per state
    always_comb begin
        unique case (flow)
            FLOW_RUN:     advance = 1'b1;
            FLOW_BLOCKED: advance = 1'b0;
            FLOW_FROZEN:  advance = 1'b0;
            default:      advance = 1'b0;
        endcase
    end

endmodule

// File: rtl/stall_valid_chain.sv
`timescale 1ns/1ps
module stall_valid_chain #(
    parameter int   STAGES     = 3,
    parameter logic RST_ACTIVE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              in_valid,
    output logic [STAGES-1:0] flags
);

    logic rst_act;
    assign rst_act = (rst == RST_ACTIVE);

    for (genvar s = 0; s < STAGES; s++) begin : g_flag
        logic q;
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst_act) begin
                    q <= 1'b0;
                end else if (advance) begin
                    q <= in_valid;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst_act) begin
                    q <= 1'b0;
                end else if (advance) begin
                    q <= g_flag[s-1].q;
                end
            end
        end
        assign flags[s] = q;
    end

    // R4 R5
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst_act)
        !advance |=> $stable(flags));

    // R7
    head_follows_input_chk: assert property (@(posedge clk) disable iff (rst_act)
        advance |=> (flags[0] == $past(in_valid)));

endmodule

// File: rtl/stall_data_chain.sv
`timescale 1ns/1ps
module stall_data_chain #(
    parameter int STAGES = 3,
    parameter int WIDTH  = 8
) (
    input  logic             clk,
    input  logic             advance,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar s = 0; s < STAGES; s++) begin : g_reg
        logic [WIDTH-1:0] q;
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (advance) begin
                    q <= din;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (advance) begin
                    q <= g_reg[s-1].q;
                end
            end
        end
    end

    assign dout = g_reg[STAGES-1].q;

endmodule

// File: rtl/stall_pipe_ctrl.sv
`timescale 1ns/1ps
module stall_pipe_ctrl
    import stall_pipe_pkg::*;
#(
    parameter int   STAGES     = 3,
    parameter int   WIDTH      = 8,
    parameter logic RST_ACTIVE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data,
    output logic             pipe_en
);

    localparam int LAST = STAGES - 1;

    logic              rst_act;
    logic [STAGES-1:0] flags;
    logic              advance;
    flow_e             flow;

    assign rst_act = (rst == RST_ACTIVE);

    stall_flow_ctl u_ctl (
        .ce         (ce),
        .last_valid (flags[LAST]),
        .sink_ready (out_ready),
        .flow       (flow),
        .advance    (advance)
    );

    stall_valid_chain #(
        .STAGES     (STAGES),
        .RST_ACTIVE (RST_ACTIVE)
    ) u_valid (
        .clk      (clk),
        .rst      (rst),
        .advance  (advance),
        .in_valid (in_valid),
        .flags    (flags)
    );

    stall_data_chain #(
        .STAGES (STAGES),
        .WIDTH  (WIDTH)
    ) u_data (
        .clk     (clk),
        .advance (advance),
        .din     (in_data),
        .dout    (out_data)
    );

    assign pipe_en   = advance;
    assign in_ready  = advance;
    assign out_valid = flags[LAST];

    // R5
    blocked_stall_chk: assert property (@(posedge clk) disable iff (rst_act)
        (out_valid && !out_ready) |-> !pipe_en);

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (rst_act)
        !pipe_en |=> $stable(out_data));

    // R3 R4
    frozen_no_accept_chk: assert property (@(posedge clk) disable iff (rst_act)
        !ce |-> (!in_ready && flow == FLOW_FROZEN));

endmodule

// File: tb/sim_stall_pipe_ctrl.sv
`timescale 1ns/1ps
module sim_stall_pipe_ctrl;

    localparam int STAGES = 3;
    localparam int WIDTH  = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ce = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [WIDTH-1:0] in_data = '0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [WIDTH-1:0] out_data;
    logic             pipe_en;

    always #4 clk = ~clk;

    stall_pipe_ctrl #(.STAGES(STAGES), .WIDTH(WIDTH), .RST_ACTIVE(1'b1)) u0 (
        .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .pipe_en(pipe_en)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit lat_on = 0;
    int n_acc = 0;
    logic [WIDTH-1:0] q_data[$];
    int q_cyc[$];
    logic [WIDTH-1:0] next_word = 8'h10;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One cycle: observe handshakes, update scoreboard, advance to next negedge
    task automatic tick();
        #1;
        // R3
        chk(pipe_en == in_ready, "R3", "pipe_en vs in_ready", pipe_en, in_ready);
        if (out_valid && out_ready && pipe_en) begin
            if (q_data.size() == 0) begin
                chk(0, "R10", "delivery with empty scoreboard", out_data, -1);
            end else begin
                logic [WIDTH-1:0] w;
                int c;
                w = q_data.pop_front();
                c = q_cyc.pop_front();
                chk(out_data == w, "R10", "delivered word", out_data, w);
                if (lat_on) chk(cyc - c == STAGES, "R9", "latency", cyc - c, STAGES);
            end
        end
        if (in_valid && in_ready) begin
            q_data.push_back(in_data);
            q_cyc.push_back(cyc);
            n_acc++;
            next_word = next_word + 8'd1;
        end
        @(posedge clk);
        cyc++;
        @(negedge clk);
    endtask

    task automatic drain();
        in_valid = 1'b0;
        out_ready = 1'b1;
        ce = 1'b1;
        for (int i = 0; i < STAGES + 2; i++) tick();
        chk(q_data.size() == 0, "R10", "items left after drain", q_data.size(), 0);
    endtask

    task automatic t_reset();
        // initial reset
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        chk(pipe_en == 1'b1, "R2", "pipe_en in reset with ce high", pipe_en, 1);
        rst = 1'b0;
        @(negedge clk);
        // mid-stream reset: fill then reset
        out_ready = 1'b0;
        for (int i = 0; i < STAGES; i++) begin
            in_valid = 1'b1;
            in_data = next_word;
            tick();
        end
        in_valid = 1'b0;
        #1;
        chk(out_valid == 1'b1, "R6", "out_valid with full pipe", out_valid, 1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid after mid-stream reset", out_valid, 0);
        rst = 1'b0;
        q_data.delete();
        q_cyc.delete();
        out_ready = 1'b1;
        @(negedge clk);
        for (int i = 0; i < STAGES + 1; i++) begin
            #1;
            chk(out_valid == 1'b0, "R1", "no item survives reset", out_valid, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_stream();
        lat_on = 1;
        out_ready = 1'b1;
        for (int i = 0; i < 20; i++) begin
            in_valid = 1'b1;
            in_data = next_word;
            #1;
            chk(in_ready == 1'b1, "R9", "in_ready while streaming", in_ready, 1);
            tick();
        end
        drain();
        lat_on = 0;
    endtask

    task automatic t_backpressure();
        int acc0;
        logic [WIDTH-1:0] held;
        acc0 = n_acc;
        out_ready = 1'b0;
        in_valid = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R2", "in_ready with empty last stage", in_ready, 1);
        for (int i = 0; i < STAGES + 4; i++) begin
            in_data = next_word;
            #1;
            if (out_valid) begin
                chk(in_ready == 1'b0, "R5", "in_ready when blocked", in_ready, 0);
                chk(pipe_en == 1'b0, "R5", "pipe_en when blocked", pipe_en, 0);
            end
            tick();
        end
        chk(n_acc - acc0 == STAGES, "R5", "items held under backpressure", n_acc - acc0, STAGES);
        held = out_data;
        in_valid = 1'b0;
        tick();
        chk(out_data == held, "R8", "out_data stable while blocked", out_data, held);
        chk(out_valid == 1'b1, "R5", "out_valid held while blocked", out_valid, 1);
        out_ready = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R2", "in_ready once sink ready", in_ready, 1);
        drain();
    endtask

    task automatic t_freeze();
        logic [WIDTH-1:0] held;
        out_ready = 1'b1;
        in_valid = 1'b1;
        for (int i = 0; i < STAGES; i++) begin
            in_data = next_word;
            tick();
        end
        #1;
        chk(out_valid == 1'b1, "R6", "out_valid before freeze", out_valid, 1);
        held = out_data;
        ce = 1'b0;
        for (int i = 0; i < 4; i++) begin
            in_data = next_word;
            #1;
            chk(in_ready == 1'b0, "R4", "in_ready while frozen", in_ready, 0);
            chk(pipe_en == 1'b0, "R3", "pipe_en while frozen", pipe_en, 0);
            chk(out_valid == 1'b1, "R4", "out_valid held while frozen", out_valid, 1);
            chk(out_data == held, "R4", "out_data held while frozen", out_data, held);
            tick();
        end
        ce = 1'b1;
        in_valid = 1'b0;
        drain();
    endtask

    task automatic t_bubbles();
        bit pat[32];
        out_ready = 1'b1;
        for (int i = 0; i < 32; i++) pat[i] = 1'b0;
        for (int i = 0; i < 12; i++) pat[i] = ((i % 3) == 0) || (i == 4);
        for (int t = 0; t < 12 + STAGES + 1; t++) begin
            in_valid = (t < 12) ? pat[t] : 1'b0;
            in_data = next_word;
            #1;
            if (t >= STAGES) begin
                chk(out_valid == pat[t - STAGES], "R7", "bubble pattern at output",
                    out_valid, pat[t - STAGES]);
            end
            tick();
        end
        drain();
    endtask

    task automatic t_random();
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            in_valid = lfsr[0] | lfsr[3];
            out_ready = lfsr[5] ^ lfsr[9];
            ce = (lfsr[7:4] != 4'hF);
            in_data = next_word;
            tick();
        end
        ce = 1'b1;
        drain();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_stream();
        t_backpressure();
        t_freeze();
        t_bubbles();
        t_random();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog expired: actual %0d expected %0d", cyc, 0);
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule